// File: doc/BRIEF.md
# Periodic Interrupt and Watchdog Supervisor

This block is the timing and safety hub of a multi-axis motion controller. A programmable clock divider raises an interrupt status flag at a fixed rate. The block notices when software fails to acknowledge that flag before the next period starts. A microsecond watchdog counts down from a loaded timeout. The block also owns the two global enables, for counters and for PWM outputs, that every downstream channel uses. When a stop condition is armed, the enables are withdrawn without software help.

Software drives the block through four write ports. The command port carries one-shot strobes: clear encoders, latch encoders, clear PWMs, acknowledge the interrupt and kick the watchdog. The mode port holds the enables and the stop options, and it reads back two sticky status flags. The divisor port sets the interrupt period, in clock cycles minus one. The timeout port sets the watchdog reload value, in microseconds. The watchdog's live count is readable. Bus address decoding and the interrupt controller sit outside this block.

Top module: `irq_wdog_supervisor`

## Requirements
- R1: A command write produces single-cycle pulses, starting the cycle after the write edge. Command bit 0 drives `enc_clear`, bit 1 drives `enc_latch` and bit 2 drives `pwm_clear`.
- R2: A mode write stores bits 0 (counter enable), 1 (PWM enable), 2 (latch on interrupt), 3 (stop on missed interrupt), 5 (interrupt enable) and 7 (stop on watchdog). `cnt_en` and `pwm_en` follow bits 0 and 1.
- R3: After a divisor write of value D, interrupt status (mode bit 6) sets D+1 cycles after the write edge. It then sets every D+1 cycles.
- R4: `irq` is high exactly when interrupt status and interrupt enable (bit 5) are both set.
- R5: Command bit 3 clears interrupt status. If a divider period ends in the same cycle, the status stays set.
- R6: A divider period that ends while interrupt status is set raises the missed flag (mode bit 4). The flag stays set through acknowledges. It clears only when a mode write has bit 4 at 1; writing a 1 to bit 6 clears status in the same way.
- R7: When a missed interrupt occurs with bit 3 set, the counter and PWM enables drop at that same edge.
- R8: With bit 2 set, `enc_latch` pulses for one cycle at the edge where interrupt status is set by the divider.
- R9: Command bit 4 loads the watchdog count from the timeout register. Writing the timeout alone does not load it. The count then falls by one every US_DIV cycles, counted from the kick, and it holds at zero.
- R10: While the watchdog count is zero and bit 7 is set, the counter and PWM enables are cleared one edge after the count reaches zero. With bit 7 clear, a zero count leaves them alone.
- R11: After reset, all mode bits, the watchdog count, `irq` and all strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Command write strobe |
| ctrl_din | input | 5 | Command bits: clear enc, latch enc, clear PWM, ack IRQ, kick |
| mode_we | input | 1 | Mode write strobe |
| mode_din | input | 8 | Mode write data; bits 4 and 6 are write-one-to-clear |
| div_we | input | 1 | Divisor write strobe; restarts the divider |
| div_din | input | 16 | Interrupt divisor (period minus one) |
| wdto_we | input | 1 | Watchdog timeout write strobe |
| wdto_din | input | 16 | Watchdog timeout in microseconds |
| mode_q | output | 8 | Mode register readback, including status bits |
| wd_count | output | 16 | Current watchdog count |
| irq | output | 1 | Gated interrupt request |
| cnt_en | output | 1 | Global counter enable |
| pwm_en | output | 1 | Global PWM enable |
| enc_clear | output | 1 | Clear-all-encoders pulse |
| enc_latch | output | 1 | Latch-all-encoders pulse |
| pwm_clear | output | 1 | Clear-all-PWMs pulse |

## Verification
The hardest cases to reach are those that depend on the exact cycle at which a divider period ends. These are a missed interrupt that stops the enables, and an acknowledge that lands on the same edge as a new period. The stimulus writes the divisor to restart the divider at a known edge. It then counts cycles from that edge, so it can land a write exactly on a period boundary or observe the cycle just before and just after. Encoder latch pulses are checked by a scoreboard that is told in advance the cycle in which each pulse is due.

// File: rtl/sup_pkg.sv
package sup_pkg;

    localparam int CMD_W  = 5;
    localparam int MODE_W = 8;

    // Command strobe decode; bit positions are fixed by software.
    typedef struct packed {
        logic kick;       // bit 4
        logic ack_irq;    // bit 3
        logic clr_pwm;    // bit 2
        logic latch_enc;  // bit 1
        logic clr_enc;    // bit 0
    } cmd_t;

    // Mode register, MSB first so an 8-bit vector casts directly.
    typedef struct packed {
        logic stop_wd;     // bit 7
        logic irq_st;      // bit 6
        logic irq_en;      // bit 5
        logic missed;      // bit 4
        logic stop_missed; // bit 3
        logic latch_irq;   // bit 2
        logic pwm_en;      // bit 1
        logic cnt_en;      // bit 0
    } mode_t;

    function automatic cmd_t decode_cmd(input logic we, input logic [CMD_W-1:0] d);
        cmd_t c;
        c = cmd_t'(d);
        if (!we) c = '0;
        return c;
    endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || restart)  cnt <= '0;
        else if (tick)       cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0)); // R3

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
    parameter int WD_W   = 16,
    parameter int US_DIV = 200
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            kick,
    input  logic [WD_W-1:0] timeout,
    output logic [WD_W-1:0] count,
    output logic            expired
);
    localparam int PRE_W = (US_DIV > 1) ? $clog2(US_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LIMIT = PRE_W'(US_DIV - 1);

    logic us_tick;

    tick_divider #(.W(PRE_W)) u_us_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (kick),
        .limit   (PRE_LIMIT),
        .tick    (us_tick)
    );

    always_ff @(posedge clk) begin
        if (rst)                          count <= '0;
        else if (kick)                    count <= timeout;
        else if (us_tick && count != '0)  count <= count - 1'b1;
    end

    assign expired = (count == '0);

    AST_WD_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !kick) |=> (count == '0)); // R9
    AST_WD_STEP: assert property (@(posedge clk) disable iff (rst)
        (count != '0 && !kick) |=>
            (count == $past(count) || count == WD_W'($past(count) - 1'b1))); // R9

endmodule

// File: rtl/sup_mode_reg.sv
module sup_mode_reg
    import sup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [MODE_W-1:0] wdata,
    input  logic              tick,
    input  logic              ack_irq,
    input  logic              wd_expired,
    output mode_t             q
);
    mode_t w;
    mode_t nxt;
    logic  missed_ev;
    logic  stop_now;

    assign w         = mode_t'(wdata);
    assign missed_ev = tick && q.irq_st;
    assign stop_now  = (missed_ev && q.stop_missed) || (wd_expired && q.stop_wd);

    always_comb begin
        nxt = q;
        if (wr) begin
            nxt.cnt_en      = w.cnt_en;
            nxt.pwm_en      = w.pwm_en;
            nxt.latch_irq   = w.latch_irq;
            nxt.stop_missed = w.stop_missed;
            nxt.irq_en      = w.irq_en;
            nxt.stop_wd     = w.stop_wd;
            if (w.missed) nxt.missed = 1'b0;
            if (w.irq_st) nxt.irq_st = 1'b0;
        end
        if (ack_irq)   nxt.irq_st = 1'b0;
        if (tick)      nxt.irq_st = 1'b1;
        if (missed_ev) nxt.missed = 1'b1;
        if (stop_now) begin
            nxt.cnt_en = 1'b0;
            nxt.pwm_en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    AST_MISSED_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(q.missed) |-> $past(q.irq_st)); // R6
    AST_MISSED_STOP: assert property (@(posedge clk) disable iff (rst)
        (tick && q.irq_st && q.stop_missed) |=> (!q.cnt_en && !q.pwm_en)); // R7
    AST_WD_STOP: assert property (@(posedge clk) disable iff (rst)
        (wd_expired && q.stop_wd) |=> (!q.cnt_en && !q.pwm_en)); // R10
    AST_TICK_SETS: assert property (@(posedge clk) disable iff (rst)
        tick |=> q.irq_st); // R5

endmodule

// File: rtl/irq_wdog_supervisor.sv
module irq_wdog_supervisor
    import sup_pkg::*;
#(
    parameter int              DIV_W     = 16,
    parameter int              WD_W      = 16,
    parameter int              US_DIV    = 200,
    parameter logic [DIV_W-1:0] DIV_RESET = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [CMD_W-1:0]  ctrl_din,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_din,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_din,
    input  logic              wdto_we,
    input  logic [WD_W-1:0]   wdto_din,
    output logic [MODE_W-1:0] mode_q,
    output logic [WD_W-1:0]   wd_count,
    output logic              irq,
    output logic              cnt_en,
    output logic              pwm_en,
    output logic              enc_clear,
    output logic              enc_latch,
    output logic              pwm_clear
);
    cmd_t             cmd;
    mode_t            mode;
    logic [DIV_W-1:0] divisor;
    logic [WD_W-1:0]  timeout;
    logic             tick;
    logic             wd_expired;

    assign cmd = decode_cmd(ctrl_we, ctrl_din);

    always_ff @(posedge clk) begin
        if (rst) begin
            divisor <= DIV_RESET;
            timeout <= '0;
        end else begin
            if (div_we)  divisor <= div_din;
            if (wdto_we) timeout <= wdto_din;
        end
    end

    tick_divider #(.W(DIV_W)) u_irq_div (
        .clk     (clk),
        .rst     (rst),
        .restart (div_we),
        .limit   (divisor),
        .tick    (tick)
    );

    sup_watchdog #(.WD_W(WD_W), .US_DIV(US_DIV)) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .kick    (cmd.kick),
        .timeout (timeout),
        .count   (wd_count),
        .expired (wd_expired)
    );

    sup_mode_reg u_mode (
        .clk        (clk),
        .rst        (rst),
        .wr         (mode_we),
        .wdata      (mode_din),
        .tick       (tick),
        .ack_irq    (cmd.ack_irq),
        .wd_expired (wd_expired),
        .q          (mode)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_clear <= 1'b0;
            enc_latch <= 1'b0;
            pwm_clear <= 1'b0;
        end else begin
            enc_clear <= cmd.clr_enc;
            enc_latch <= cmd.latch_enc || (tick && mode.latch_irq);
            pwm_clear <= cmd.clr_pwm;
        end
    end

    assign mode_q = mode;
    assign irq    = mode.irq_st && mode.irq_en;
    assign cnt_en = mode.cnt_en;
    assign pwm_en = mode.pwm_en;

    AST_LATCH_ON_IRQ: assert property (@(posedge clk) disable iff (rst)
        (tick && mode.latch_irq) |=> (enc_latch && mode_q[6])); // R8
    AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (rst)
        (enc_clear && !cmd.clr_enc) |=> !enc_clear); // R1

endmodule

// File: tb/tb_irq_wdog_supervisor.sv
module tb_irq_wdog_supervisor;
    localparam int US_DIV = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [4:0]  ctrl_din = '0;
    logic        mode_we = 1'b0;
    logic [7:0]  mode_din = '0;
    logic        div_we = 1'b0;
    logic [15:0] div_din = '0;
    logic        wdto_we = 1'b0;
    logic [15:0] wdto_din = '0;
    logic [7:0]  mode_q;
    logic [15:0] wd_count;
    logic        irq, cnt_en, pwm_en, enc_clear, enc_latch, pwm_clear;

    irq_wdog_supervisor #(.US_DIV(US_DIV)) dut (
        .clk(clk), .rst(rst),
        .ctrl_we(ctrl_we), .ctrl_din(ctrl_din),
        .mode_we(mode_we), .mode_din(mode_din),
        .div_we(div_we), .div_din(div_din),
        .wdto_we(wdto_we), .wdto_din(wdto_din),
        .mode_q(mode_q), .wd_count(wd_count), .irq(irq),
        .cnt_en(cnt_en), .pwm_en(pwm_en),
        .enc_clear(enc_clear), .enc_latch(enc_latch), .pwm_clear(pwm_clear)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int k0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard of expected encoder latch pulses (cycle number, requirement tag).
    int    exp_cyc[$];
    string exp_tag[$];

    always @(negedge clk) begin
        if (!rst && enc_latch) begin
            if (exp_cyc.size() == 0) begin
                chk("R8 unexpected latch pulse", 32'(cyc), 32'hFFFF_FFFF);
            end else begin
                chk(exp_tag.pop_front(), 32'(cyc), 32'(exp_cyc.pop_front()));
            end
        end
    end

    // Called 1ns after an edge; the write is taken at the next edge.
    task automatic wr(input int port, input logic [15:0] d);
        case (port)
            0: begin ctrl_we = 1'b1; ctrl_din = d[4:0]; end
            1: begin mode_we = 1'b1; mode_din = d[7:0]; end
            2: begin div_we  = 1'b1; div_din  = d;      end
            default: begin wdto_we = 1'b1; wdto_din = d; end
        endcase
        @(posedge clk); #1;
        ctrl_we = 1'b0; mode_we = 1'b0; div_we = 1'b0; wdto_we = 1'b0;
    endtask

    task automatic wait_cyc(input int target);
        while (cyc < target) begin
            @(posedge clk); #1;
        end
    endtask

    initial begin
        #150000;
        chk("watchdog expired", 32'd0, 32'd1);
        done = 1'b1;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R11 reset state
        chk("R11 mode", 32'(mode_q), 32'h00);
        chk("R11 wd count", 32'(wd_count), 32'h0);
        chk("R11 irq", 32'(irq), 32'h0);
        chk("R11 strobes", 32'({enc_clear, enc_latch, pwm_clear}), 32'h0);

        // R1 command strobes
        wr(0, 16'h0007);
        exp_cyc.push_back(cyc); exp_tag.push_back("R1 latch strobe cycle");
        chk("R1 enc_clear pulse", 32'(enc_clear), 32'h1);
        chk("R1 pwm_clear pulse", 32'(pwm_clear), 32'h1);
        @(posedge clk); #1;
        chk("R1 pulses end", 32'({enc_clear, pwm_clear}), 32'h0);

        // R2 mode bits
        wr(1, 16'h0003);
        chk("R2 mode", 32'(mode_q), 32'h03);
        chk("R2 enables", 32'({cnt_en, pwm_en}), 32'h3);

        // R3 / R6 / R7 periodic status, missed, stop on missed
        wr(1, 16'h000B);
        wr(2, 16'd9);
        k0 = cyc;
        wait_cyc(k0 + 9);
        chk("R3 status before period", 32'(mode_q[6]), 32'h0);
        wait_cyc(k0 + 10);
        chk("R3 status at period", 32'(mode_q[6]), 32'h1);
        chk("R4 irq gated off", 32'(irq), 32'h0);
        wait_cyc(k0 + 19);
        chk("R7 enables before miss", 32'({mode_q[4], cnt_en, pwm_en}), 32'h3);
        wait_cyc(k0 + 20);
        chk("R6 missed set", 32'(mode_q[4]), 32'h1);
        chk("R7 enables dropped", 32'({cnt_en, pwm_en}), 32'h0);

        // R5 / R6 acknowledge and sticky missed flag
        wr(2, 16'd1000);
        wr(0, 16'h0008);
        chk("R5 ack clears status", 32'(mode_q[6]), 32'h0);
        chk("R6 missed sticky after ack", 32'(mode_q[4]), 32'h1);
        wr(1, 16'h0010);
        chk("R6 missed cleared by W1C", 32'(mode_q), 32'h00);

        // R4 irq gating
        wr(2, 16'd9);
        k0 = cyc;
        wait_cyc(k0 + 10);
        chk("R4 status set, irq off", 32'({mode_q[6], irq}), 32'h2);
        wr(1, 16'h0020);
        chk("R4 irq on", 32'(irq), 32'h1);
        wr(1, 16'h0000);
        chk("R4 irq off with status", 32'({mode_q[6], irq}), 32'h2);

        // R5 ack on the same edge as a period end
        wait_cyc(k0 + 29);
        wr(0, 16'h0008);
        chk("R5 tick wins over ack", 32'(mode_q[6]), 32'h1);

        // R8 latch on interrupt
        wr(2, 16'd1000);
        wr(0, 16'h0008);
        wr(1, 16'h0054);
        chk("R8 mode setup", 32'(mode_q), 32'h04);
        wr(2, 16'd9);
        k0 = cyc;
        exp_cyc.push_back(k0 + 10); exp_tag.push_back("R8 latch at period 1");
        exp_cyc.push_back(k0 + 20); exp_tag.push_back("R8 latch at period 2");
        wait_cyc(k0 + 21);
        wr(1, 16'h0050);
        wr(2, 16'd1000);
        repeat (5) @(posedge clk);
        #1;
        chk("R8 all latches seen", 32'(exp_cyc.size()), 32'h0);

        // R9 watchdog load and countdown
        wr(3, 16'd3);
        chk("R9 timeout write does not load", 32'(wd_count), 32'h0);
        wr(0, 16'h0010);
        k0 = cyc;
        chk("R9 kick loads", 32'(wd_count), 32'd3);
        wait_cyc(k0 + 4);
        chk("R9 before first step", 32'(wd_count), 32'd3);
        wait_cyc(k0 + 5);
        chk("R9 first step", 32'(wd_count), 32'd2);
        wait_cyc(k0 + 15);
        chk("R9 reaches zero", 32'(wd_count), 32'd0);
        wait_cyc(k0 + 25);
        chk("R9 holds zero", 32'(wd_count), 32'd0);

        // R10 no stop when disarmed, stop when armed
        wr(1, 16'h0003);
        repeat (3) @(posedge clk);
        #1;
        chk("R10 disarmed keeps enables", 32'({cnt_en, pwm_en}), 32'h3);
        wr(0, 16'h0010);
        k0 = cyc;
        wr(1, 16'h0083);
        wait_cyc(k0 + 15);
        chk("R10 enables at expiry edge", 32'({wd_count == 0, cnt_en, pwm_en}), 32'h7);
        wait_cyc(k0 + 16);
        chk("R10 enables stopped", 32'({mode_q[7], cnt_en, pwm_en}), 32'h4);

        done = 1'b1;
    end

    initial begin
        wait (done);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule